// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This controller sits between a coin acceptor and a beverage release mechanism. The acceptor gives two single-cycle pulses, one for a 5-cent coin and one for a 10-cent coin. The controller adds each coin to a running credit. When the credit reaches or passes the 15-cent price, it raises a one-cycle release pulse and starts again from zero. The machine gives no change, so any amount above the price is discarded.

The design is a Moore machine. The release pulse comes from a dedicated state register, not from the coin inputs. A coin that arrives while the release pulse is high counts toward the next purchase, starting from zero credit. Normally at most one coin arrives per cycle. A cycle with both pulses high breaks that rule, so the controller treats it as void and keeps its credit.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst_ni` is low, `vend_o` is low and the credit is zero. After reset is released, a full 15 cents must be inserted before a release occurs.
- R2: A cycle with `nickel_i`=1 and `dime_i`=0 adds 5 cents to the credit.
- R3: A cycle with `dime_i`=1 and `nickel_i`=0 adds 10 cents to the credit.
- R4: When a coin takes the credit to 15 cents or more, `vend_o` is high for exactly the one cycle after the clock edge that samples that coin.
- R5: Credit above 15 cents is discarded. After 10+10 the controller releases, and the next purchase again needs a full 15 cents.
- R6: A coin sampled in a cycle where `vend_o` is high is credited from zero.
- R7: A cycle with both coin inputs high leaves the credit unchanged and causes no release.
- R8: With no coin input, the credit is held for any number of cycles and `vend_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nickel_i | input | 1 | Single-cycle 5-cent coin pulse |
| dime_i | input | 1 | Single-cycle 10-cent coin pulse |
| vend_o | output | 1 | One-cycle beverage release pulse |

## Verification
The bench applies every sequence of five coin-input symbols (none, 5, 10, both) from a fresh reset. An arithmetic model checks `vend_o` in every cycle. This covers the following faults:
- If the overpayment excess were carried over, a release would come one coin too early.
- A coin lost during the release cycle would show as a missing later release.
- If a both-high cycle were read as a 10-cent coin, a release would appear too early.
- A reset that did not clear a partial credit would let a lone 5-cent coin trigger a release.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [1:0] {
    COIN_NONE  = 2'd0,
    COIN_SMALL = 2'd1,
    COIN_LARGE = 2'd2,
    COIN_VOID  = 2'd3
  } coin_e;
endpackage

// File: rtl/vend_coin_dec.sv
module vend_coin_dec
  import vend_pkg::*;
#(
  parameter int unsigned SMALL = 5,
  parameter int unsigned LARGE = 10,
  parameter int unsigned VW    = $clog2(LARGE + 1)
) (
  input  logic          small_i,
  input  logic          large_i,
  output coin_e         kind_o,
  output logic [VW-1:0] value_o
);
  always_comb begin
    unique case ({large_i, small_i})
      2'b01:   begin kind_o = COIN_SMALL; value_o = VW'(SMALL); end
      2'b10:   begin kind_o = COIN_LARGE; value_o = VW'(LARGE); end
      2'b11:   begin kind_o = COIN_VOID;  value_o = '0;         end
      default: begin kind_o = COIN_NONE;  value_o = '0;         end
    endcase
  end
endmodule

// File: rtl/vend_credit.sv
module vend_credit
  import vend_pkg::*;
#(
  parameter int unsigned PRICE = 15,
  parameter int unsigned LARGE = 10,
  parameter int unsigned VW    = $clog2(LARGE + 1),
  parameter int unsigned CW    = $clog2(PRICE),
  parameter int unsigned SW    = $clog2(PRICE + LARGE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  coin_e         kind_i,
  input  logic [VW-1:0] value_i,
  output logic [CW-1:0] credit_o,
  output logic          disp_o
);
  logic [CW-1:0] credit_q, credit_d;
  logic          disp_q, disp_d;
  logic [SW-1:0] base, sum;

  // release state restarts the count at zero
  assign base = disp_q ? '0 : SW'(credit_q);
  assign sum  = base + SW'(value_i);

  always_comb begin
    credit_d = credit_q;
    disp_d   = 1'b0;
    if (kind_i == COIN_VOID) begin
      credit_d = base[CW-1:0];
    end else if (sum >= SW'(PRICE)) begin
      credit_d = '0;
      disp_d   = 1'b1;
    end else begin
      credit_d = sum[CW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q <= '0;
      disp_q   <= 1'b0;
    end else begin
      credit_q <= credit_d;
      disp_q   <= disp_d;
    end
  end

  assign credit_o = credit_q;
  assign disp_o   = disp_q;
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int unsigned SMALL = 5,
  parameter int unsigned LARGE = 10,
  parameter int unsigned PRICE = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nickel_i,
  input  logic dime_i,
  output logic vend_o
);
  localparam int unsigned VW = $clog2(LARGE + 1);
  localparam int unsigned CW = $clog2(PRICE);
  localparam int unsigned SW = $clog2(PRICE + LARGE);

  coin_e         coin_kind;
  logic [VW-1:0] coin_val;
  logic [CW-1:0] credit_q;

  vend_coin_dec #(.SMALL(SMALL), .LARGE(LARGE), .VW(VW)) u_dec (
    .small_i (nickel_i),
    .large_i (dime_i),
    .kind_o  (coin_kind),
    .value_o (coin_val)
  );

  vend_credit #(.PRICE(PRICE), .LARGE(LARGE), .VW(VW), .CW(CW), .SW(SW)) u_credit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kind_i   (coin_kind),
    .value_i  (coin_val),
    .credit_o (credit_q),
    .disp_o   (vend_o)
  );
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
  parameter int unsigned SMALL = 5,
  parameter int unsigned LARGE = 10,
  parameter int unsigned PRICE = 15,
  parameter int unsigned CW    = $clog2(PRICE)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          nickel_i,
  input logic          dime_i,
  input logic          vend_o,
  input logic [CW-1:0] credit_q
);
  // R4
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vend_o |=> !vend_o);

  // R7
  void_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nickel_i && dime_i && !vend_o) |=> (!vend_o && $stable(credit_q)));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nickel_i && !dime_i && !vend_o) |=> (!vend_o && $stable(credit_q)));

  // R2
  small_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nickel_i && !dime_i && !vend_o && (32'(credit_q) + SMALL < PRICE))
      |=> (32'(credit_q) == 32'($past(credit_q)) + SMALL));

  // R5
  clear_after_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vend_o && !nickel_i && !dime_i) |=> (credit_q == '0));

  // R6
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vend_o && dime_i && !nickel_i) |=> (32'(credit_q) == LARGE));
endmodule

bind vend_ctrl vend_ctrl_chk #(.SMALL(SMALL), .LARGE(LARGE), .PRICE(PRICE)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .nickel_i (nickel_i),
  .dime_i   (dime_i),
  .vend_o   (vend_o),
  .credit_q (credit_q)
);

// File: tb/vend_ctrl_bench.sv
module vend_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nickel = 1'b0;
  logic dime = 1'b0;
  logic vend;
  int   n_vec = 0;
  int   n_bad = 0;
  int   m_credit = 0;
  bit   m_disp = 1'b0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  vend_ctrl u_vend_ctrl (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .nickel_i (nickel),
    .dime_i   (dime),
    .vend_o   (vend)
  );

  task automatic check(input string req, input logic exp);
    n_vec++;
    if (vend !== exp) begin
      n_bad++;
      $display("FAIL %s: vend_o=%b expected %b", req, vend, exp);
    end
  endtask

  // R1: hold reset, check output low, release
  task automatic do_reset();
    @(negedge clk);
    nickel = 1'b0; dime = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    m_credit = 0; m_disp = 1'b0;
  endtask

  // code: 0 none, 1 five, 2 ten, 3 both
  task automatic step(input int code);
    int base, sum;
    string req;
    nickel = code[0];
    dime   = code[1];
    base = m_disp ? 0 : m_credit;
    if (code == 3) begin
      req = "R7"; m_credit = base; m_disp = 1'b0;
    end else begin
      sum = base + (code == 1 ? 5 : code == 2 ? 10 : 0);
      req = (code == 0) ? "R8" : m_disp ? "R6" : (code == 1) ? "R2" : "R3";
      if (sum >= 15) begin
        req = (sum > 15) ? "R5" : "R4";
        m_disp = 1'b1; m_credit = 0;
      end else begin
        m_disp = 1'b0; m_credit = sum;
      end
    end
    @(negedge clk);
    check(req, m_disp);
  endtask

  initial begin
    do_reset();
    // R1: partial credit cleared by reset
    step(2);
    do_reset();
    step(1);
    step(0);
    // R5: 10+10 releases, then 5+5 alone must not
    do_reset();
    step(2); step(2); step(0); step(1); step(1); step(0); step(1);
    // R8: long idle keeps 10 cents
    do_reset();
    step(2);
    for (int i = 0; i < 20; i++) step(0);
    step(1);
    // sweep all 5-symbol sequences, two idle cycles to expose residue
    for (int s = 0; s < 1024; s++) begin
      do_reset();
      for (int k = 0; k < 5; k++) step((s >> (2 * k)) & 3);
      step(0);
      step(0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule